// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the software-visible face of a multi-channel event timer. It takes simple single-beat register requests (valid, write, address, byte size, 64-bit data). It checks the size and alignment of each request and places 32-bit accesses in the correct half of the 64-bit registers. It serves the global registers itself: a read-only capabilities word, a configuration register with a counter enable, an interrupt-status window, and a free-running main counter. Requests for the per-channel registers go to the channel blocks on a decoded side port, and the read data from that port is returned on the response.

The main counter advances by one per clock while enabled and holds its value while disabled. When the enable bit changes, the block emits a one-cycle start or stop pulse. A start pulse also follows any write to the counter made while it runs, so the channels rearm from the new count. The count is visible to the channels at all times. A read response arrives one cycle after the read request.

Top module: `evt_timer_regfront`

## Requirements
- R1: Only byte sizes 4 and 8 are accepted. A write of any other size changes no register and raises no side-port strobe. A read of any other size returns zero.
- R2: An access whose address is not a multiple of its size is treated like a bad size: the write is dropped and the read returns zero.
- R3: A 4-byte access with address bit 2 set works on bits 63:32. Write data moves up by 32 with the lane mask, and the read returns the upper half in bits 31:0. A 4-byte read always has bits 63:32 of the response at zero.
- R4: The capabilities word at offset 0x000 ignores writes. It reads as follows: bits 63:32 hold the tick period in femtoseconds (10^15 / 2^24, truncated), bits 31:16 hold the vendor identifier, bit 13 is 0 for a 32-bit counter, bits 12:8 hold the channel count minus one, and bits 7:0 hold revision 1.
- R5: The configuration register at 0x010 stores written bits under the lane mask, except bit 1, which always reads 0. Bit 0 is the counter enable.
- R6: The counter resets to 0. At each clock where the enable is set and no counter write occurs, it increments by one (wrapping at 2^32). It holds while the enable is clear.
- R7: The counter at 0x0F0 reads zero-extended to 64 bits. A write merges under the lane mask, and the write takes priority over the increment in that cycle. A counter write made while enabled gives a start pulse in the next cycle.
- R8: A 0-to-1 change of the enable gives a one-cycle start pulse, and a 1-to-0 change gives a one-cycle stop pulse. Each pulse appears in the cycle after the write.
- R9: An accepted access to 0x100 + 0x20*n (n below the channel count) raises the side-port read or write strobe in the same cycle with index n. The field code is 0 for config at +0x00, 1 for comparator at +0x08, and 2 for route at +0x10. Lane data and mask are forwarded, and a read returns the side-port data.
- R10: Every read request gets a response one cycle later. Unmapped offsets, including +0x18 inside a channel window and windows past the last channel, read zero.
- R11: The status window at 0x020 reads the channel interrupt lines, zero-extended. A write there gives, in the same cycle, a clear strobe equal to masked write data AND the current status lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset into the block |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, right-aligned for 4-byte writes |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 64 | Read response data |
| irq_status | input | NCH | Per-channel interrupt status lines |
| isr_clear | output | NCH | Per-channel status clear strobe |
| ch_wr_en | output | 1 | Channel register write strobe |
| ch_rd_en | output | 1 | Channel register read strobe |
| ch_idx | output | IW | Addressed channel |
| ch_field | output | 2 | Addressed channel register |
| ch_wdata | output | 64 | Lane-aligned write data |
| ch_wmask | output | 64 | Lane mask for the write |
| ch_rdata | input | 64 | Read data from the addressed channel |
| cnt_value | output | CNT_W | Current main counter value |
| cnt_running | output | 1 | Counter enable state |
| start_pulse | output | 1 | Channels restart from the counter value |
| stop_pulse | output | 1 | Counter has been frozen |

## Verification
A counter write can arrive in a cycle where the running counter would also increment. The enable can also be toggled while a count is in progress. These are the cases where the counter's own advance and a register update compete for the same edge. Directed sequences write the counter (whole and by upper or lower half) while counting is enabled, and disable the counter right after idle cycles. Random traffic mixes configuration writes, which flip the enable, with counter writes and reads. A cycle-accurate bench model decides the winner (the written value replaces the increment) and predicts the restart and stop pulses. Every clock, the bench compares the count and the pulses against that model.

// File: rtl/evt_timer_pkg.sv
// Shared types and constants for the event timer register front end.
// Assumes byte offsets relative to the block base.
package evt_timer_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CAPS,
        RG_CFG,
        RG_ISR,
        RG_CNT,
        RG_CHAN
    } region_e;

    localparam int OFS_CAPS    = 'h000;
    localparam int OFS_CFG     = 'h010;
    localparam int OFS_ISR     = 'h020;
    localparam int OFS_CNT     = 'h0F0;
    localparam int OFS_CH_BASE = 'h100;
    localparam int CH_STRIDE   = 'h020;

    // Replace the bits selected by mask with the matching data bits.
    function automatic logic [63:0] merge64(input logic [63:0] old_v,
                                            input logic [63:0] data,
                                            input logic [63:0] mask);
        return (old_v & ~mask) | (data & mask);
    endfunction

endpackage

// File: rtl/evt_access_decode.sv
// Request decoder: checks size and alignment, builds the lane mask and
// lane-aligned data, and classifies the offset into a register region.
// Assumes one request per cycle and that AW covers the last channel window.
module evt_access_decode
    import evt_timer_pkg::*;
#(
    parameter int AW  = 12,
    parameter int NCH = 8,
    parameter int IW  = $clog2(NCH)
) (
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_size,
    input  logic [63:0]   req_wdata,
    output logic          acc_ok,
    output logic          acc_wide,
    output logic          hi_half,
    output region_e       region,
    output logic [IW-1:0] chan_idx,
    output logic [1:0]    chan_field,
    output logic [63:0]   lane_data,
    output logic [63:0]   lane_mask
);
    localparam int CH_END = OFS_CH_BASE + NCH * CH_STRIDE;

    logic [AW-1:0] base;
    logic [AW-1:0] rel;
    logic          size4;
    logic          align_ok;
    logic          in_chan;

    // Size / alignment qualification and half-word steering.
    always_comb begin
        size4    = (req_size == 4'd4);
        acc_wide = (req_size == 4'd8);
        align_ok = acc_wide ? (req_addr[2:0] == 3'b000) : (req_addr[1:0] == 2'b00);
        acc_ok   = req_valid && (size4 || acc_wide) && align_ok;
        hi_half  = size4 && req_addr[2];
        if (acc_wide) begin
            lane_mask = '1;
            lane_data = req_wdata;
        end else if (hi_half) begin
            lane_mask = {32'hFFFF_FFFF, 32'h0};
            lane_data = {req_wdata[31:0], 32'h0};
        end else begin
            lane_mask = {32'h0, 32'hFFFF_FFFF};
            lane_data = {32'h0, req_wdata[31:0]};
        end
    end

    // Offset classification into global registers or a channel window.
    always_comb begin
        base       = {req_addr[AW-1:3], 3'b000};
        rel        = base - AW'(OFS_CH_BASE);
        chan_idx   = IW'(rel >> 5);
        chan_field = 2'(rel >> 3);
        in_chan    = (int'(base) >= OFS_CH_BASE) && (int'(base) < CH_END)
                     && (chan_field != 2'b11);
        if (int'(base) == OFS_CAPS)      region = RG_CAPS;
        else if (int'(base) == OFS_CFG)  region = RG_CFG;
        else if (int'(base) == OFS_ISR)  region = RG_ISR;
        else if (int'(base) == OFS_CNT)  region = RG_CNT;
        else if (in_chan)                region = RG_CHAN;
        else                             region = RG_NONE;
    end

endmodule

// File: rtl/evt_main_counter.sv
// Configuration register, main counter and enable-edge pulse generator.
// Assumes cfg_we and cnt_we are never high together (one register per request).
module evt_main_counter
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cnt_we,
    input  logic [63:0]      wdata,
    input  logic [63:0]      wmask,
    output logic [63:0]      cfg_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             start_pulse,
    output logic             stop_pulse
);
    logic [63:0]      cfg_next;
    logic [63:0]      cnt_wide;
    logic [CNT_W-1:0] cnt_written;
    logic             en_next;

    // Next configuration value, legacy routing bit forced clear.
    always_comb begin
        cfg_next    = merge64(cfg_q, wdata, wmask);
        cfg_next[1] = 1'b0;
        en_next     = cfg_we ? cfg_next[0] : cfg_q[0];
        cnt_wide    = merge64({{(64-CNT_W){1'b0}}, cnt_q}, wdata, wmask);
        cnt_written = cnt_wide[CNT_W-1:0];
    end

    // Register update: config, counter (write beats increment), edge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            cnt_q       <= '0;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
        end else begin
            if (cfg_we) cfg_q <= cfg_next;
            if (cnt_we) cnt_q <= cnt_written;
            else if (cfg_q[0]) cnt_q <= cnt_q + 1'b1;
            start_pulse <= (en_next && !cfg_q[0]) || (cnt_we && cfg_q[0]);
            stop_pulse  <= cfg_q[0] && !en_next;
        end
    end

    // R6: disabled counter without a write holds.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q[0] && !cnt_we) |=> $stable(cnt_q));
    // R6: enabled counter without a write advances by one.
    a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[0] && !cnt_we) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    // R8: enable rising edge comes with a start pulse.
    a_r8_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q[0]) |-> start_pulse);
    // R8: enable falling edge comes with a stop pulse.
    a_r8_stop_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_q[0]) |-> stop_pulse);
    // R8: the two pulses never coincide.
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && stop_pulse));

endmodule

// File: rtl/evt_read_mux.sv
// Read data selection by region with half-word return for 4-byte reads.
// Assumes region has already been qualified by the decoder.
module evt_read_mux
    import evt_timer_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CNT_W = 32
) (
    input  region_e          region,
    input  logic             acc_wide,
    input  logic             hi_half,
    input  logic [63:0]      caps_word,
    input  logic [63:0]      cfg_word,
    input  logic [NCH-1:0]   irq_status,
    input  logic [CNT_W-1:0] cnt_word,
    input  logic [63:0]      ch_rdata,
    output logic [63:0]      rd_data
);
    logic [63:0] full;

    // Pick the 64-bit register, then narrow for 4-byte reads.
    always_comb begin
        unique case (region)
            RG_CAPS: full = caps_word;
            RG_CFG:  full = cfg_word;
            RG_ISR:  full = {{(64-NCH){1'b0}}, irq_status};
            RG_CNT:  full = {{(64-CNT_W){1'b0}}, cnt_word};
            RG_CHAN: full = ch_rdata;
            default: full = '0;
        endcase
        if (acc_wide)     rd_data = full;
        else if (hi_half) rd_data = {32'h0, full[63:32]};
        else              rd_data = {32'h0, full[31:0]};
    end

endmodule

// File: rtl/evt_timer_regfront.sv
// Register front end of a multi-channel event timer: decodes requests,
// holds configuration and main counter, forwards channel accesses and
// returns read data one cycle after the request.
// Assumes ch_rdata answers combinationally for the strobed channel.
module evt_timer_regfront
    import evt_timer_pkg::*;
#(
    parameter int          AW        = 12,
    parameter int          NCH       = 8,
    parameter int          CNT_W     = 32,
    parameter int          TICK_LOG2 = 24,
    parameter logic [15:0] VENDOR_ID = 16'hA5C1,
    parameter int          IW        = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [3:0]       req_size,
    input  logic [63:0]      req_wdata,
    output logic             rsp_valid,
    output logic [63:0]      rsp_rdata,
    input  logic [NCH-1:0]   irq_status,
    output logic [NCH-1:0]   isr_clear,
    output logic             ch_wr_en,
    output logic             ch_rd_en,
    output logic [IW-1:0]    ch_idx,
    output logic [1:0]       ch_field,
    output logic [63:0]      ch_wdata,
    output logic [63:0]      ch_wmask,
    input  logic [63:0]      ch_rdata,
    output logic [CNT_W-1:0] cnt_value,
    output logic             cnt_running,
    output logic             start_pulse,
    output logic             stop_pulse
);
    localparam logic [63:0] TICK_FS   = 64'd1000000000000000 / (64'd1 << TICK_LOG2);
    localparam logic        WIDE_CNT  = (CNT_W > 32);
    localparam logic [63:0] CAPS_WORD = {TICK_FS[31:0], VENDOR_ID, 2'b00, WIDE_CNT,
                                         5'(NCH - 1), 8'h01};

    logic        acc_ok, acc_wide, hi_half;
    region_e     region;
    logic [63:0] lane_data, lane_mask, cfg_q, rd_data;
    logic        wr_ok, cfg_we, cnt_we;

    evt_access_decode #(.AW(AW), .NCH(NCH), .IW(IW)) u_decode (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .acc_ok    (acc_ok),
        .acc_wide  (acc_wide),
        .hi_half   (hi_half),
        .region    (region),
        .chan_idx  (ch_idx),
        .chan_field(ch_field),
        .lane_data (lane_data),
        .lane_mask (lane_mask)
    );

    // Write strobes and channel side-port steering.
    always_comb begin
        wr_ok     = acc_ok && req_write;
        cfg_we    = wr_ok && (region == RG_CFG);
        cnt_we    = wr_ok && (region == RG_CNT);
        ch_wr_en  = wr_ok && (region == RG_CHAN);
        ch_rd_en  = acc_ok && !req_write && (region == RG_CHAN);
        ch_wdata  = lane_data;
        ch_wmask  = lane_mask;
        isr_clear = (wr_ok && (region == RG_ISR))
                    ? (lane_data[NCH-1:0] & lane_mask[NCH-1:0] & irq_status) : '0;
    end

    evt_main_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cnt_we     (cnt_we),
        .wdata      (lane_data),
        .wmask      (lane_mask),
        .cfg_q      (cfg_q),
        .cnt_q      (cnt_value),
        .start_pulse(start_pulse),
        .stop_pulse (stop_pulse)
    );

    assign cnt_running = cfg_q[0];

    evt_read_mux #(.NCH(NCH), .CNT_W(CNT_W)) u_rdmux (
        .region    (region),
        .acc_wide  (acc_wide),
        .hi_half   (hi_half),
        .caps_word (CAPS_WORD),
        .cfg_word  (cfg_q),
        .irq_status(irq_status),
        .cnt_word  (cnt_value),
        .ch_rdata  (ch_rdata),
        .rd_data   (rd_data)
    );

    // Read response register: every read answered next cycle, bad ones with zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= (req_valid && !req_write && acc_ok) ? rd_data : '0;
        end
    end

    // R1: an illegal size raises no strobe.
    a_r1_size_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != 4'd4 && req_size != 4'd8)
        |-> (!ch_wr_en && !ch_rd_en && isr_clear == '0));
    // R2: a misaligned 8-byte access raises no strobe.
    a_r2_align_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 4'd8 && req_addr[2:0] != 3'b000)
        |-> (!ch_wr_en && !ch_rd_en && isr_clear == '0));
    // R10: each read request is answered in the next cycle.
    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    // R5: setting the legacy bit by write leaves it clear.
    a_r5_legacy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && lane_mask[1] && lane_data[1]) |=> !cfg_q[1]);

endmodule

// File: tb/evt_timer_regfront_tb_top.sv
`timescale 1ns/1ps
module evt_timer_regfront_tb_top;
    localparam int AW = 12, NCH = 8, IW = 3, CW = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0] req_size = '0;
    logic [63:0] req_wdata = '0;
    logic rsp_valid; logic [63:0] rsp_rdata;
    logic [NCH-1:0] irq_status = '0, isr_clear;
    logic ch_wr_en, ch_rd_en; logic [IW-1:0] ch_idx; logic [1:0] ch_field;
    logic [63:0] ch_wdata, ch_wmask, ch_rdata;
    logic [CW-1:0] cnt_value; logic cnt_running, start_pulse, stop_pulse;

    always #2 clk = ~clk;

    function automatic logic [63:0] chan_word(input int idx, input int f);
        return {16'hC0DE, 8'(idx), 8'(f), 32'h1000_0000 + 32'(idx * 16 + f)};
    endfunction
    assign ch_rdata = chan_word(int'(ch_idx), int'(ch_field));

    evt_timer_regfront dut_i (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [63:0] m_cfg = '0;
    logic [31:0] m_cnt = '0;
    bit exp_start = 0, exp_stop = 0;
    string pulse_tag = "R8";

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit ok_of(input logic [11:0] a, input logic [3:0] sz);
        if (sz == 8) return a[2:0] == 0;
        if (sz == 4) return a[1:0] == 0;
        return 0;
    endfunction
    function automatic logic [63:0] mask_of(input logic [11:0] a, input logic [3:0] sz);
        if (sz == 8) return '1;
        return a[2] ? 64'hFFFF_FFFF_0000_0000 : 64'h0000_0000_FFFF_FFFF;
    endfunction
    function automatic logic [63:0] data_of(input logic [11:0] a, input logic [3:0] sz,
                                            input logic [63:0] d);
        if (sz == 8) return d;
        return a[2] ? {d[31:0], 32'h0} : {32'h0, d[31:0]};
    endfunction
    function automatic bit chan_of(input logic [11:0] b);
        return b >= 12'h100 && b < 12'h200 && b[4:3] != 2'b11;
    endfunction
    function automatic string tag_of(input logic [11:0] a, input logic [3:0] sz);
        logic [11:0] b = a & 12'hFF8;
        if (sz != 4 && sz != 8) return "R1";
        if (!ok_of(a, sz)) return "R2";
        if (sz == 4 && a[2]) return "R3";
        if (b == 12'h000) return "R4";
        if (b == 12'h010) return "R5";
        if (b == 12'h020) return "R11";
        if (b == 12'h0F0) return "R7";
        if (chan_of(b)) return "R9";
        return "R10";
    endfunction
    function automatic logic [63:0] exp_read(input logic [11:0] a, input logic [3:0] sz);
        logic [11:0] b = a & 12'hFF8;
        logic [63:0] full;
        if (!ok_of(a, sz)) return '0;
        if (b == 12'h000)
            full = {32'(64'd1000000000000000 / 64'd16777216), 16'hA5C1, 3'b000, 5'd7, 8'h01};
        else if (b == 12'h010) full = m_cfg;
        else if (b == 12'h020) full = {56'h0, irq_status};
        else if (b == 12'h0F0) full = {32'h0, m_cnt};
        else if (chan_of(b)) full = chan_word(int'((b - 12'h100) >> 5), int'(b[4:3]));
        else full = '0;
        if (sz == 8) return full;
        return a[2] ? {32'h0, full[63:32]} : {32'h0, full[31:0]};
    endfunction

    // Model one clock edge.
    task automatic upd(input bit cfg_w, input bit cnt_w, input logic [63:0] d,
                       input logic [63:0] m);
        bit old_en = m_cfg[0];
        logic [63:0] t;
        if (cfg_w) begin
            m_cfg = (m_cfg & ~m) | (d & m);
            m_cfg[1] = 1'b0;
        end
        if (cnt_w) begin
            t = ({32'h0, m_cnt} & ~m) | (d & m);
            m_cnt = t[31:0];
        end else if (old_en) m_cnt = m_cnt + 1;
        exp_start = (m_cfg[0] && !old_en) || (cnt_w && old_en);
        exp_stop  = old_en && !m_cfg[0];
        pulse_tag = (cnt_w && old_en) ? "R7" : "R8";
    endtask

    task automatic post_checks();
        chk("R6", 64'(cnt_value), 64'(m_cnt));
        chk(pulse_tag, 64'(start_pulse), 64'(exp_start));
        chk("R8", 64'(stop_pulse), 64'(exp_stop));
        chk("R5", 64'(cnt_running), 64'(m_cfg[0]));
    endtask

    task automatic access(input bit wr, input logic [11:0] a, input logic [3:0] sz,
                          input logic [63:0] d);
        bit ok = ok_of(a, sz);
        logic [63:0] m = mask_of(a, sz), ld = data_of(a, sz, d), er;
        logic [11:0] b = a & 12'hFF8;
        bit ch = chan_of(b);
        string tg = tag_of(a, sz);
        req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        #1;
        chk(ok ? "R9" : tg, 64'(ch_wr_en), 64'(ok && wr && ch));
        chk(ok ? "R9" : tg, 64'(ch_rd_en), 64'(ok && !wr && ch));
        if (ok && ch) begin
            chk("R9", 64'(ch_idx), 64'((b - 12'h100) >> 5));
            chk("R9", 64'(ch_field), 64'(b[4:3]));
            if (wr) begin
                chk(sz == 4 && a[2] ? "R3" : "R9", ch_wmask, m);
                chk(sz == 4 && a[2] ? "R3" : "R9", ch_wdata & m, ld & m);
            end
        end
        chk(ok ? "R11" : tg, 64'(isr_clear),
            (ok && wr && b == 12'h020) ? 64'((ld & m) & 64'(irq_status)) : 64'h0);
        er = exp_read(a, sz);
        @(posedge clk);
        upd(ok && wr && b == 12'h010, ok && wr && b == 12'h0F0, ld, m);
        @(negedge clk);
        req_valid = 0;
        chk("R10", 64'(rsp_valid), 64'(!wr));
        if (!wr) chk(tg, rsp_rdata, er);
        post_checks();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            upd(0, 0, '0, '0);
            @(negedge clk);
            post_checks();
        end
    endtask

    function automatic logic [11:0] pick_addr();
        case ($urandom % 8)
            0: return 12'h000;
            1: return 12'h010;
            2: return 12'h020;
            3: return 12'h0F0;
            4: return 12'(12'h100 + ($urandom % 10) * 32 + ($urandom % 4) * 8 + ($urandom % 2) * 4);
            5: return 12'($urandom);
            6: return 12'h014;
            default: return 12'h0F4;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        exp_start = 0; exp_stop = 0;
        post_checks();                                   // reset state, R6
        chk("R10", 64'(rsp_valid), 64'h0);
        // R4: constant capabilities, writes ignored
        access(0, 12'h000, 8, '0);
        access(1, 12'h000, 8, 64'hFFFF_FFFF_FFFF_FFFF);
        access(0, 12'h000, 8, '0);
        access(0, 12'h004, 4, '0);                       // R3 upper half
        // R6: counter holds while disabled
        idle(4);
        access(0, 12'h0F0, 8, '0);
        // R8/R5: enable with legacy bit set
        access(1, 12'h010, 8, 64'h0000_0000_0000_0003);
        access(0, 12'h010, 8, '0);
        idle(5);
        access(0, 12'h0F0, 8, '0);                       // R7 zero-extended, running
        // R7: counter write while running wins and restarts
        access(1, 12'h0F0, 4, 64'h0000_0000_FFFF_FFF0);
        idle(20);                                        // wrap through 2^32
        access(1, 12'h0F4, 4, 64'h0000_0000_1234_5678);  // R3 upper-half write, count ignores
        access(1, 12'h0F0, 8, 64'hAAAA_BBBB_0000_0100);
        // R1 / R2: dropped and zero-returning accesses
        access(1, 12'h010, 2, 64'h0);
        access(1, 12'h014, 8, 64'h0);
        access(0, 12'h0F0, 1, '0);
        access(0, 12'h0F2, 4, '0);
        access(1, 12'h0F0, 8, 64'h0);                    // R2 check of aligned form
        // R8: disable freezes the count
        access(1, 12'h010, 4, 64'h0);
        idle(3);
        access(0, 12'h0F0, 4, '0);
        // R9: channel forwarding
        access(0, 12'h1EC, 4, '0);
        access(1, 12'h150, 8, 64'h0123_4567_89AB_CDEF);
        access(0, 12'h100, 8, '0);
        access(1, 12'h12C, 4, 64'h0000_0000_DEAD_BEEF);
        // R10: unmapped
        access(0, 12'h030, 8, '0);
        access(0, 12'h0F8, 8, '0);
        access(0, 12'h118, 8, '0);
        access(0, 12'h200, 8, '0);
        access(1, 12'h200, 8, 64'hFFFF);
        // R11: status window
        irq_status = 8'hA5;
        access(0, 12'h020, 8, '0);
        access(1, 12'h020, 8, 64'h0000_0000_0000_00F0);
        access(1, 12'h024, 4, 64'h0000_0000_0000_00FF);
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] sz;
            case ($urandom % 8)
                0, 1, 2: sz = 4;
                3, 4, 5: sz = 8;
                6: sz = 2;
                default: sz = 4'($urandom % 3);
            endcase
            irq_status = 8'($urandom);
            access(1'($urandom), pick_addr(), sz, {$urandom, $urandom});
            if ($urandom % 4 == 0) idle(1);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule